// File: doc/BRIEF.md
# Indirect Pixel Writer

This block turns register writes into masked pixel writes at a moving destination address. A host writes a linear destination byte address, a 32-bit pixel-enable mask and two colour registers. It then streams data words into one of eight data aliases. Each data word is split into pixels at the current address. Once the last pixel of the word is done, the address steps one transfer in the direction that the alias names.

Three pixel modes set how a data word is cut up. Expansion mode gives 32 one-bit pixels, each painted in the foreground or the background colour. The background may be made transparent. 8-bit mode gives four byte pixels. 24-bit mode gives one pixel from the low 24 bits. A second setting picks the pixel address size: one byte, or one 32-bit long. A line is always 2048 pixels long. All register writes are queued in a 32-entry buffer and are applied in order. The pixel port accepts a ready signal, so the pixel output can be stalled.

Top module: `indirect_pixel_writer`

## Requirements
- R1: After reset, px_valid_o is low and wr_ready_o is high. The destination register is 0, the mask is all ones, and both colours are 0.
- R2: Register selects are 0 = destination (low AW bits), 1 = mask, 2 = foreground, 3 = background, and 8 to 15 = data aliases. With long addressing (addr_long_i=1), pixel (x,y) is at byte address x*4 + y*8192. With byte addressing it is at x + y*2048.
- R3: The data alias select bits [2:0] pick the step applied after the word: 0 +X, 1 +Y, 2 -Y, 3 -X, 4 +X+Y, 5 -X+Y, 6 +X-Y, 7 -X-Y.
- R4: A horizontal step is (pixels per word) x (pixel bytes). A vertical step is 2048 x (pixel bytes). Pixels per word is 32 for mode 0 (expansion), 4 for mode 1 (8-bit), and 1 for modes 2 and 3 (24-bit).
- R5: Pixel k of a word (k=0 is leftmost, taken from the MSB end) is written at destination + k x (pixel bytes), and only if mask bit 31-k is set. Masked pixels produce no write.
- R6: In expansion mode, data bit 31-k selects the foreground colour (1) or the background colour (0). When bg_transp_i is 1, pixels whose bit is 0 are not written.
- R7: In 8-bit mode, pixel k carries data bits [31-8k -: 8], zero-extended to 32 bits.
- R8: In 24-bit mode, the single pixel carries data bits [23:0] with bits [31:24] of px_data_o zero.
- R9: Register writes take effect strictly in order and none is lost. Up to 32 writes wait in the queue. wr_ready_o is low only while the queue is full.
- R10: The destination address wraps modulo 2^AW. Negative steps use two's-complement arithmetic.
- R11: While px_valid_o is high and px_ready_i is low, px_valid_o, px_addr_o and px_data_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Register write request |
| wr_sel_i | input | 4 | Register select |
| wr_data_i | input | 32 | Register write data |
| wr_ready_o | output | 1 | Write accepted when high |
| mode_i | input | 2 | Pixel mode, sampled when a data word starts |
| addr_long_i | input | 1 | 1: 4-byte pixel address size, 0: 1-byte |
| bg_transp_i | input | 1 | Background is transparent in expansion mode |
| px_valid_o | output | 1 | Pixel write valid |
| px_ready_i | input | 1 | Pixel write accepted |
| px_addr_o | output | AW | Pixel byte address |
| px_data_o | output | 32 | Pixel value |

## Verification
A write accepted at a clock edge enters the queue at that edge. The engine can pop it at the next edge. For a data word, pixel 0 is first offered in the cycle after that pop. Each later pixel position takes one more accepted or skipped cycle. Because masking and stalls move these times around, the bench's reference model records the expected pixel writes in order at the moment each write is accepted. At each falling edge it compares the offered pixel against the head of that list whenever valid and ready are both high. Queue depth is measured by holding ready low and counting accepted writes, and any pixel that appears when none is expected is reported.

// File: rtl/ipw_pkg.sv
package ipw_pkg;
  localparam logic [1:0] MODE_EXP  = 2'd0;
  localparam logic [1:0] MODE_PX8  = 2'd1;
  localparam logic [1:0] MODE_PX24 = 2'd2;

  localparam logic [1:0] SEL_DST  = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_FG   = 2'd2;
  localparam logic [1:0] SEL_BG   = 2'd3;

  typedef struct packed {
    logic [3:0]  sel;
    logic [31:0] data;
  } reg_wr_t;

  function automatic logic [5:0] px_per_word(logic [1:0] m);
    case (m)
      MODE_EXP: return 6'd32;
      MODE_PX8: return 6'd4;
      default:  return 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/ipw_fifo.sv
module ipw_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> !(cnt_q > (PW+1)'(DEPTH)));
endmodule

// File: rtl/ipw_stepper.sv
module ipw_stepper #(
  parameter int AW       = 24,
  parameter int PITCH_PX = 2048
) (
  input  logic [AW-1:0] base_i,
  input  logic [2:0]    dir_i,
  input  logic [5:0]    ppw_i,
  input  logic          long_i,
  output logic [AW-1:0] next_o
);
  localparam logic [AW-1:0] PITCH = AW'(PITCH_PX);

  logic [AW-1:0] h_step, v_step, h_term, v_term;
  logic          dx_pos, dx_neg, dy_pos, dy_neg;

  always_comb begin
    h_step = long_i ? (AW'(ppw_i) << 2) : AW'(ppw_i);
    v_step = long_i ? (PITCH << 2) : PITCH;
    {dx_pos, dx_neg, dy_pos, dy_neg} = 4'b0000;
    case (dir_i)
      3'd0: dx_pos = 1'b1;
      3'd1: dy_pos = 1'b1;
      3'd2: dy_neg = 1'b1;
      3'd3: dx_neg = 1'b1;
      3'd4: {dx_pos, dy_pos} = 2'b11;
      3'd5: {dx_neg, dy_pos} = 2'b11;
      3'd6: {dx_pos, dy_neg} = 2'b11;
      default: {dx_neg, dy_neg} = 2'b11;
    endcase
    h_term = dx_pos ? h_step : (dx_neg ? ({AW{1'b0}} - h_step) : '0);
    v_term = dy_pos ? v_step : (dy_neg ? ({AW{1'b0}} - v_step) : '0);
    next_o = base_i + h_term + v_term;
  end
endmodule

// File: rtl/ipw_engine.sv
module ipw_engine
  import ipw_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  reg_wr_t       entry_i,
  input  logic          empty_i,
  output logic          pop_o,
  input  logic [1:0]    mode_i,
  input  logic          addr_long_i,
  input  logic          bg_transp_i,
  input  logic [AW-1:0] next_addr_i,
  output logic [AW-1:0] base_o,
  output logic [2:0]    dir_o,
  output logic [5:0]    ppw_o,
  output logic          long_o,
  output logic          px_valid_o,
  input  logic          px_ready_i,
  output logic [AW-1:0] px_addr_o,
  output logic [31:0]   px_data_o
);
  typedef enum logic {ST_IDLE, ST_EMIT} st_e;

  st_e           st_q;
  logic [AW-1:0] dst_q;
  logic [31:0]   mask_q, fg_q, bg_q, word_q;
  logic [2:0]    dir_q;
  logic [1:0]    mode_q;
  logic          long_q, transp_q;
  logic [4:0]    idx_q;

  logic       mask_bit, cur_bit, en, advance, last;
  logic [4:0] shamt;
  logic [31:0] shifted;
  logic [5:0] ppw;

  always_comb begin
    ppw      = px_per_word(mode_q);
    mask_bit = mask_q[5'd31 - idx_q];
    cur_bit  = word_q[5'd31 - idx_q];
    shamt    = 5'd24 - {idx_q[1:0], 3'b000};
    shifted  = word_q >> shamt;
    case (mode_q)
      MODE_EXP: begin
        en        = mask_bit & (cur_bit | ~transp_q);
        px_data_o = cur_bit ? fg_q : bg_q;
      end
      MODE_PX8: begin
        en        = mask_bit;
        px_data_o = {24'h0, shifted[7:0]};
      end
      default: begin
        en        = mask_bit;
        px_data_o = {8'h0, word_q[23:0]};
      end
    endcase
    pop_o      = (st_q == ST_IDLE) && !empty_i;
    px_valid_o = (st_q == ST_EMIT) && en;
    px_addr_o  = dst_q + (long_q ? (AW'(idx_q) << 2) : AW'(idx_q));
    advance    = !px_valid_o || px_ready_i;
    last       = (6'(idx_q) == ppw - 6'd1);
    base_o     = dst_q;
    dir_o      = dir_q;
    ppw_o      = ppw;
    long_o     = long_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      dst_q    <= '0;
      mask_q   <= '1;
      fg_q     <= '0;
      bg_q     <= '0;
      word_q   <= '0;
      dir_q    <= '0;
      mode_q   <= MODE_EXP;
      long_q   <= 1'b0;
      transp_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (pop_o) begin
          if (!entry_i.sel[3]) begin
            case (entry_i.sel[1:0])
              SEL_DST:  dst_q  <= entry_i.data[AW-1:0];
              SEL_MASK: mask_q <= entry_i.data;
              SEL_FG:   fg_q   <= entry_i.data;
              default:  bg_q   <= entry_i.data;
            endcase
          end else begin
            word_q   <= entry_i.data;
            dir_q    <= entry_i.sel[2:0];
            mode_q   <= mode_i;
            long_q   <= addr_long_i;
            transp_q <= bg_transp_i;
            idx_q    <= '0;
            st_q     <= ST_EMIT;
          end
        end
        default: if (advance) begin
          if (last) begin
            dst_q <= next_addr_i;
            st_q  <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_valid_o && !px_ready_i |=> px_valid_o && $stable(px_addr_o) && $stable(px_data_o));

  // R6
  exp_colour_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_valid_o && mode_q == MODE_EXP |-> (px_data_o == fg_q) || (px_data_o == bg_q));

  // R8
  wide_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_valid_o && mode_q[1] |-> px_data_o[31:24] == 8'h00);
endmodule

// File: rtl/indirect_pixel_writer.sv
module indirect_pixel_writer
  import ipw_pkg::*;
#(
  parameter int AW       = 24,
  parameter int DEPTH    = 32,
  parameter int PITCH_PX = 2048
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [3:0]    wr_sel_i,
  input  logic [31:0]   wr_data_i,
  output logic          wr_ready_o,
  input  logic [1:0]    mode_i,
  input  logic          addr_long_i,
  input  logic          bg_transp_i,
  output logic          px_valid_o,
  input  logic          px_ready_i,
  output logic [AW-1:0] px_addr_o,
  output logic [31:0]   px_data_o
);
  localparam int EW = $bits(reg_wr_t);

  reg_wr_t       wr_entry, head;
  logic [EW-1:0] head_raw;
  logic          push, pop, empty, full;
  logic [AW-1:0] base, next_addr;
  logic [2:0]    dir;
  logic [5:0]    ppw;
  logic          long_sel;

  assign wr_entry   = '{sel: wr_sel_i, data: wr_data_i};
  assign wr_ready_o = !full;
  assign push       = wr_valid_i && !full;
  assign head       = reg_wr_t'(head_raw);

  ipw_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .din_i(wr_entry),
    .pop_i(pop), .dout_o(head_raw),
    .empty_o(empty), .full_o(full)
  );

  ipw_stepper #(.AW(AW), .PITCH_PX(PITCH_PX)) u_stepper (
    .base_i(base), .dir_i(dir), .ppw_i(ppw), .long_i(long_sel), .next_o(next_addr)
  );

  ipw_engine #(.AW(AW)) u_engine (
    .clk_i, .rst_ni,
    .entry_i(head), .empty_i(empty), .pop_o(pop),
    .mode_i, .addr_long_i, .bg_transp_i,
    .next_addr_i(next_addr),
    .base_o(base), .dir_o(dir), .ppw_o(ppw), .long_o(long_sel),
    .px_valid_o, .px_ready_i, .px_addr_o, .px_data_o
  );
endmodule

// File: tb/indirect_pixel_writer_bench.sv
module indirect_pixel_writer_bench;
  localparam int AW = 24;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [3:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] mode = 2'd0;
  logic addr_long = 1'b1, bg_transp = 1'b0;
  logic px_valid, px_ready = 1'b1;
  logic [AW-1:0] px_addr;
  logic [31:0] px_data;

  int checks = 0, errors = 0, rmode = 0, seen = 0;
  bit done = 0;
  string cur_tag = "R1";

  int m_dst, m_mask, m_fg, m_bg;
  int q_addr[$], q_data[$];
  string q_tag[$];

  always #5 clk = ~clk;

  indirect_pixel_writer #(.AW(AW)) u_indirect_pixel_writer (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .mode_i(mode), .addr_long_i(addr_long), .bg_transp_i(bg_transp),
    .px_valid_o(px_valid), .px_ready_i(px_ready), .px_addr_o(px_addr), .px_data_o(px_data)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int step_addr(int a, int dir, int ppw, int bpb);
    int dx, dy;
    dx = (dir == 0 || dir == 4 || dir == 6) ? 1 : ((dir == 3 || dir == 5 || dir == 7) ? -1 : 0);
    dy = (dir == 1 || dir == 4 || dir == 5) ? 1 : ((dir == 2 || dir == 6 || dir == 7) ? -1 : 0);
    return (a + dx * ppw * bpb + dy * 2048 * bpb) & AMASK;
  endfunction

  // reference model applied in acceptance order
  task automatic model(int sel, int data);
    int ppw, bpb, val;
    bit en, b;
    if (sel == 0) m_dst = data & AMASK;
    else if (sel == 1) m_mask = data;
    else if (sel == 2) m_fg = data;
    else if (sel == 3) m_bg = data;
    else if (sel >= 8) begin
      ppw = (mode == 0) ? 32 : ((mode == 1) ? 4 : 1);
      bpb = addr_long ? 4 : 1;
      for (int k = 0; k < ppw; k++) begin
        en = m_mask[31-k];
        if (mode == 0) begin
          b = data[31-k];
          if (!b && bg_transp) en = 0;
          val = b ? m_fg : m_bg;
        end else if (mode == 1) val = (data >> (24 - 8*k)) & 255;
        else val = data & 32'h00FF_FFFF;
        if (en) begin
          q_addr.push_back((m_dst + k * bpb) & AMASK);
          q_data.push_back(val);
          q_tag.push_back(cur_tag);
        end
      end
      m_dst = step_addr(m_dst, sel - 8, ppw, bpb);
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_sel = 4'(sel);
    wr_data = data;
    model(sel, data);
  endtask

  task automatic wr_end();
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    wr_end();
    for (int i = 0; i < 20000 && q_addr.size() != 0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk({cur_tag, " R9 pending"}, q_addr.size(), 0);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && px_valid && px_ready) begin
      seen++;
      if (q_addr.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected pixel got %h/%h exp none", px_addr, px_data);
      end else begin
        chk({q_tag[0], " addr"}, int'(px_addr), q_addr.pop_front());
        chk({q_tag[0], " data"}, px_data, q_data.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  // ready driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      px_ready = (rmode == 0) ? 1'b1 : ((rmode == 2) ? 1'b0 : ($urandom_range(0, 9) < 7));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int acc, start;
    m_dst = 0; m_mask = 32'hFFFF_FFFF; m_fg = 0; m_bg = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 px_valid", px_valid, 0);
    chk("R1 wr_ready", wr_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 px_valid after release", px_valid, 0);
    // R1 reset register values: one 24-bit word at dst 0 with full mask
    cur_tag = "R1"; mode = 2'd2; addr_long = 1'b1;
    wr(8, 32'hAB12_3456);
    drain();

    // R2 R5 glyph, expansion, down alias
    cur_tag = "R5"; mode = 2'd0; bg_transp = 1'b0;
    wr(0, 100*4 + 150*8192); wr(1, 32'hFFF0_0000);
    wr(2, 32'h00AA_55CC); wr(3, 32'h0000_0011);
    start = seen;
    for (int r = 0; r < 20; r++) wr(9, 32'hF0F0_0000 ^ (r << 22));
    drain();
    chk("R5 glyph pixel count", seen - start, 240);
    // R2 next write lands 20 lines below the glyph origin
    cur_tag = "R2";
    wr(1, 32'h8000_0000);
    wr(8, 32'h8000_0000);
    drain();

    // R6 transparent background
    cur_tag = "R6"; bg_transp = 1'b1; rmode = 1;
    wr(0, 64); wr(1, 32'hFFFF_FFFF);
    wr(8, 32'h8421_C3A5); wr(13, 32'h0F0F_0001); wr(8, 32'h0);
    drain();
    bg_transp = 1'b0;

    // R3 all eight aliases, 24-bit pixels, long addressing
    cur_tag = "R3"; mode = 2'd2; rmode = 0;
    wr(0, 500*4 + 600*8192); wr(1, 32'h8000_0000);
    for (int d = 0; d < 8; d++) wr(8 + d, 32'h0100_0000 + d);
    wr(8, 32'h00FF_FFFF);
    drain();

    // R7 R4 8-bit pixels, byte addressing, masked lanes
    cur_tag = "R7"; mode = 2'd1; addr_long = 1'b0; rmode = 1;
    wr(0, 2048*3 + 10); wr(1, 32'hA000_0000);
    wr(8, 32'h1122_3344); wr(9, 32'h5566_7788);
    wr(1, 32'hF000_0000);
    wr(15, 32'h99AA_BBCC); wr(8, 32'hDDEE_FF00);
    drain();
    cur_tag = "R4"; mode = 2'd0; addr_long = 1'b1;
    wr(0, 0); wr(2, 32'h7); wr(3, 32'h9);
    wr(8, 32'h1234_5678); wr(8, 32'hFFFF_0000);
    drain();

    // R8 24-bit pixel with top byte set in data
    cur_tag = "R8"; mode = 2'd3;
    wr(1, 32'hFFFF_FFFF); wr(0, 40);
    wr(8, 32'hFF80_8080); wr(11, 32'h7F01_0203); wr(8, 32'h1);
    drain();

    // R10 wrap at top and below zero
    cur_tag = "R10"; mode = 2'd2;
    wr(0, AMASK - 3);
    wr(8, 32'h11); wr(8, 32'h22);
    wr(0, 0);
    wr(10, 32'h33); wr(15, 32'h44); wr(8, 32'h55);
    drain();

    // R9 R11 queue depth under full stall
    cur_tag = "R9"; mode = 2'd0; rmode = 2;
    wr(1, 32'hFFFF_FFFF);
    wr_end();
    repeat (4) @(negedge clk);
    acc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!wr_ready) break;
      wr_valid = 1'b1; wr_sel = 4'd8; wr_data = 32'hC0DE_0000 + i;
      model(8, 32'hC0DE_0000 + i);
      acc++;
    end
    wr_valid = 1'b0;
    chk("R9 accepted while stalled", acc, 33);
    chk("R11 valid held during stall", px_valid, 1);
    chk("R9 ready low when full", wr_ready, 0);
    cur_tag = "R11";
    rmode = 1;
    drain();
    rmode = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule